// File: doc/BRIEF.md
# Silence-Triggered Mute Controller

This block sits beside the sample path of a stereo playback converter. It watches every accepted left/right sample pair. Once the stream has stayed silent on both channels for a long stretch, it declares a silence condition. It combines that condition with a three-state mute pin mode and a software mute bit to decide whether the channel is muted.

While mute holds, the block produces a 16-bit gain that shrinks by about 1/64 of itself per sample, which gives an exponential fade. The downstream filter multiplies its samples by this gain. When mute lifts, the gain jumps back to full scale on the very next sample, so playback resumes without a ramp.

The pin mode reflects how the board drives the mute pin: held low, held high, or left floating. In the floating case, silence alone may mute. In the held-high case, silence mutes only when the detection enable bit is set.

Top module: `silmute_ctrl`

## Requirements
- R1: The silence flag `zero_n` goes low in the cycle after the clock edge that accepts the 1024th consecutive accepted pair whose left and right samples are both zero. It stays high after only 1023 such pairs.
- R2: An accepted pair with either channel non-zero clears the silence condition: `zero_n` is high in the cycle after that edge, and the run count restarts from zero.
- R3: Cycles with `smp_valid` low are ignored by the silence detector, whatever the sample data. They neither advance nor break a run.
- R4: Pin mode code 0 (pin driven low) forces `mute_active` high.
- R5: `reg_mute` high forces `mute_active` high, whatever the pin mode.
- R6: Under pin mode code 2 (floating), the silence condition alone drives `mute_active`. Under codes 1 (driven high) and 3 (treated as driven high), the silence condition mutes only when `det_en` is 1.
- R7: On each accepted sample while `mute_active` is high, the gain g becomes g − (g >> 6). When g >> 6 is zero, the step is one instead, so the gain reaches zero and then stays at zero.
- R8: On each accepted sample while `mute_active` is low, the gain becomes 0xFFFF.
- R9: After reset the run count is zero, `zero_n` is high and the gain is 0xFFFF.
- R10: The gain does not change in cycles without an accepted sample, even if the mute inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe marking a new sample pair |
| smp_left | input | 24 | Left channel sample |
| smp_right | input | 24 | Right channel sample |
| pin_mode | input | 2 | Mute pin state: 0 driven low, 1 driven high, 2 floating, 3 as driven high |
| det_en | input | 1 | Lets silence mute while the pin is driven high |
| reg_mute | input | 1 | Software mute request |
| zero_n | output | 1 | Low while the silence condition holds |
| mute_active | output | 1 | Final mute decision |
| gain | output | 16 | Soft-mute gain, 0xFFFF is unity |

## Verification
A run count that is off by one shows as `zero_n` falling one accepted pair early or late, so the bench probes both sides of the 1024 boundary. A count that fails to clear, or that advances on invalid cycles, shows within one sample as a stale or early flag. A wrong gain state appears at the `gain` port on the very next accepted sample, because every step is compared with a model built from R7 and R8. The mute combination is combinational, so an error there shows in the same cycle the inputs change.

// File: rtl/silmute_pkg.sv
package silmute_pkg;

    localparam int SAMPLE_W_DEF    = 24;
    localparam int GAIN_W_DEF      = 16;
    localparam int RUN_LEN_DEF     = 1024;
    localparam int DECAY_SHIFT_DEF = 6;

    typedef enum logic [1:0] {
        PIN_DRIVEN_LOW  = 2'd0,
        PIN_DRIVEN_HIGH = 2'd1,
        PIN_FLOATING    = 2'd2,
        PIN_RESERVED    = 2'd3
    } pin_mode_e;

    // Individual reasons that may request a mute.
    typedef struct packed {
        logic by_pin;
        logic by_reg;
        logic by_silence;
    } mute_cause_t;

    // Decide whether silence is allowed to mute for a given pin state.
    function automatic logic silence_may_mute(pin_mode_e mode, logic det_en);
        logic allow;
        case (mode)
            PIN_FLOATING: allow = 1'b1;
            PIN_DRIVEN_LOW: allow = det_en;
            default: allow = det_en;
        endcase
        return allow;
    endfunction

endpackage

// File: rtl/silmute_run_det.sv
module silmute_run_det #(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                zero_cond
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] run_cnt;
    logic             pair_silent;

    assign pair_silent = (smp_left == '0) && (smp_right == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (smp_valid) begin
            if (!pair_silent) begin
                run_cnt <= '0;
            end else if (run_cnt != CNT_MAX) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign zero_cond = (run_cnt == CNT_MAX);

endmodule

// File: rtl/silmute_decide.sv
module silmute_decide
    import silmute_pkg::*;
(
    input  logic [1:0] pin_mode,
    input  logic       det_en,
    input  logic       reg_mute,
    input  logic       zero_cond,
    output logic       mute
);

    pin_mode_e   mode;
    mute_cause_t cause;

    assign mode = pin_mode_e'(pin_mode);

    always_comb begin
        cause.by_pin     = (mode == PIN_DRIVEN_LOW);
        cause.by_reg     = reg_mute;
        cause.by_silence = zero_cond && silence_may_mute(mode, det_en);
    end

    assign mute = |cause;

endmodule

// File: rtl/silmute_gain.sv
module silmute_gain #(
    parameter int GAIN_W      = 16,
    parameter int DECAY_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic              mute,
    output logic [GAIN_W-1:0] gain
);

    logic [GAIN_W-1:0] gain_q;
    logic [GAIN_W-1:0] frac;
    logic [GAIN_W-1:0] step;
    logic [GAIN_W-1:0] decayed;

    always_comb begin
        frac = gain_q >> DECAY_SHIFT;
        if (frac != '0) begin
            step = frac;
        end else if (gain_q != '0) begin
            step = GAIN_W'(1);
        end else begin
            step = '0;
        end
        decayed = gain_q - step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= '1;
        end else if (smp_valid) begin
            gain_q <= mute ? decayed : '1;
        end
    end

    assign gain = gain_q;

endmodule

// File: rtl/silmute_ctrl.sv
module silmute_ctrl
    import silmute_pkg::*;
#(
    parameter int SAMPLE_W    = SAMPLE_W_DEF,
    parameter int GAIN_W      = GAIN_W_DEF,
    parameter int RUN_LEN     = RUN_LEN_DEF,
    parameter int DECAY_SHIFT = DECAY_SHIFT_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic [1:0]          pin_mode,
    input  logic                det_en,
    input  logic                reg_mute,
    output logic                zero_n,
    output logic                mute_active,
    output logic [GAIN_W-1:0]   gain
);

    logic zero_cond;
    logic mute;

    silmute_run_det #(
        .SAMPLE_W(SAMPLE_W),
        .RUN_LEN (RUN_LEN)
    ) run_det_i (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .smp_left (smp_left),
        .smp_right(smp_right),
        .zero_cond(zero_cond)
    );

    silmute_decide decide_i (
        .pin_mode (pin_mode),
        .det_en   (det_en),
        .reg_mute (reg_mute),
        .zero_cond(zero_cond),
        .mute     (mute)
    );

    silmute_gain #(
        .GAIN_W     (GAIN_W),
        .DECAY_SHIFT(DECAY_SHIFT)
    ) gain_i (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .mute     (mute),
        .gain     (gain)
    );

    assign zero_n      = ~zero_cond;
    assign mute_active = mute;

endmodule

// File: rtl/silmute_chk.sv
module silmute_chk #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_left,
    input logic [SAMPLE_W-1:0] smp_right,
    input logic [1:0]          pin_mode,
    input logic                det_en,
    input logic                reg_mute,
    input logic                zero_n,
    input logic                mute_active,
    input logic [GAIN_W-1:0]   gain
);

    assert_nonzero_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && (smp_left != '0 || smp_right != '0)) |=> zero_n);

    assert_flag_needs_sample_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(zero_n) |-> $past(smp_valid));

    assert_pin_low_mutes_R4: assert property (@(posedge clk) disable iff (rst)
        (pin_mode == 2'd0) |-> mute_active);

    assert_reg_mute_R5: assert property (@(posedge clk) disable iff (rst)
        reg_mute |-> mute_active);

    assert_high_pin_no_det_R6: assert property (@(posedge clk) disable iff (rst)
        (pin_mode == 2'd1 && !det_en && !reg_mute) |-> !mute_active);

    assert_decay_not_rising_R7: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mute_active) |=> (gain <= $past(gain)));

    assert_unmuted_full_R8: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !mute_active) |=> (gain == '1));

    assert_gain_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(gain));

endmodule

bind silmute_ctrl silmute_chk #(
    .SAMPLE_W(SAMPLE_W),
    .GAIN_W  (GAIN_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .pin_mode   (pin_mode),
    .det_en     (det_en),
    .reg_mute   (reg_mute),
    .zero_n     (zero_n),
    .mute_active(mute_active),
    .gain       (gain)
);

// File: tb/silmute_ctrl_tb.sv
module silmute_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic [1:0]  pin_mode = 2'd1;
    logic        det_en = 1'b0;
    logic        reg_mute = 1'b0;
    logic        zero_n;
    logic        mute_active;
    logic [15:0] gain;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [15:0] model_g;

    always #5 clk = ~clk;

    silmute_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_left   (smp_left),
        .smp_right  (smp_right),
        .pin_mode   (pin_mode),
        .det_en     (det_en),
        .reg_mute   (reg_mute),
        .zero_n     (zero_n),
        .mute_active(mute_active),
        .gain       (gain)
    );

    // Row: {silence expected, pin_mode[1:0], det_en, reg_mute, expected mute}
    localparam int NROWS = 12;
    localparam logic [5:0] ROWS [NROWS] = '{
        6'b000001, 6'b001000, 6'b010000, 6'b001100, 6'b010011, 6'b011000,
        6'b110001, 6'b101000, 6'b101101, 6'b111000, 6'b111101, 6'b100001
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] decay(input logic [15:0] g);
        logic [15:0] s;
        s = g >> 6;
        if (s == 16'd0 && g != 16'd0) s = 16'd1;
        return g - s;
    endfunction

    // One accepted sample; outputs sampled on the following falling edge.
    task automatic send(input logic [23:0] l, input logic [23:0] r);
        smp_left  = l;
        smp_right = r;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) send(24'd0, 24'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 zero_n after reset", zero_n, 1);
        check("R9 gain after reset", gain, 16'hFFFF);
        check("R9 mute after reset", mute_active, 0);

        // Table walk over mute combinations (R4 R5 R6)
        for (int k = 0; k < NROWS; k++) begin
            if (k > 0 && ROWS[k][5] && !ROWS[k-1][5]) begin
                pin_mode = 2'd1; det_en = 1'b0; reg_mute = 1'b0;
                zeros(1024);
            end
            pin_mode = ROWS[k][4:3];
            det_en   = ROWS[k][2];
            reg_mute = ROWS[k][1];
            #1;
            check("R6 table silence flag", zero_n, !ROWS[k][5]);
            check("R4 R5 R6 table mute", mute_active, ROWS[k][0]);
            @(negedge clk);
        end

        // R2: non-zero right channel clears at once
        pin_mode = 2'd1; det_en = 1'b0; reg_mute = 1'b0;
        send(24'd0, 24'h000100);
        check("R2 right non-zero clears", zero_n, 1);

        // R1 boundary, with invalid non-zero data in between (R3)
        zeros(600);
        smp_left = 24'hABCDEF; smp_right = 24'h123456;
        repeat (4) @(negedge clk);
        zeros(423);
        check("R1 after 1023 silent pairs", zero_n, 1);
        send(24'd0, 24'd0);
        check("R1 after 1024 silent pairs", zero_n, 0);
        smp_left = 24'h800000;
        repeat (3) @(negedge clk);
        check("R3 invalid data ignored", zero_n, 0);
        send(24'h000001, 24'd0);
        check("R2 left non-zero clears", zero_n, 1);
        zeros(1023);
        check("R2 count restarted", zero_n, 1);

        // Gain decay under pin-low mute (R7)
        pin_mode = 2'd0;
        model_g = 16'hFFFF;
        for (int i = 0; i < 8; i++) begin
            send(24'h000010, 24'h000020);
            model_g = decay(model_g);
            check("R7 decay step", gain, model_g);
        end
        // R10: hold while idle even when mute changes
        pin_mode = 2'd1;
        repeat (5) @(negedge clk);
        check("R10 gain held when idle", gain, model_g);
        // R8: release on next sample
        send(24'h000010, 24'h000020);
        check("R8 release to full scale", gain, 16'hFFFF);

        // Long decay to zero under software mute (R5 R7)
        reg_mute = 1'b1;
        model_g = 16'hFFFF;
        for (int i = 0; i < 800; i++) begin
            send(24'h000005, 24'h000005);
            model_g = decay(model_g);
            if (gain != model_g) check("R7 long decay", gain, model_g);
        end
        check("R7 reaches zero", gain, 16'd0);
        send(24'h000005, 24'h000005);
        check("R7 stays at zero", gain, 16'd0);
        reg_mute = 1'b0;
        send(24'h000005, 24'h000005);
        check("R8 recover from zero", gain, 16'hFFFF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule